// File: doc/BRIEF.md
# Precision-Time Event Frame Classifier

This block watches an Ethernet frame delivered one byte per clock with start and end markers. While the frame streams past, it picks out the destination MAC address and the Ethertype. For IPv4 frames it also takes the header length and the destination address. For IPv6 frames it takes the destination address. It then reads the UDP destination port and, from the time-protocol header, the version nibble and the 16-bit sequence number. The time-protocol header is found in one of three places: right after the Ethernet header for a raw frame, after the UDP header for IPv4 (this position uses the header length), or after a fixed 40-byte IPv6 header plus the UDP header.

Detection works on two levels. Eleven field comparators each test one extracted field against a fixed or configured value, and each comparator can be disabled by a parameter mask. Fourteen rules each AND two comparator outputs, and each rule can be disabled by a rule mask. The four IPv4 rules also require an IPv4 frame, and the four IPv6 rules require an IPv6 frame. A frame is reported when some unmasked rule holds, the block is enabled, the version found in the header is accepted, and the frame was long enough to carry the sequence number. The report is a single-cycle pulse in the clock after the last byte, and the sequence number is valid in that same cycle.

Top module: `ptp_frame_classifier`

## Requirements
- R1: Comparator index k corresponds to bit k of `cfg_param_mask`, and a 1 in that bit forces comparator k to false. The fixed comparators are: 0 = IPv4 destination 224.0.1.129; 1 = IPv4 destination 224.0.0.107; 2 = IPv6 destination FF0x::181; 3 = IPv6 destination FF02::6B; 4 = UDP port 319; 5 = UDP port 320; 6 = Ethertype 0x88F7; 8 = MAC 01-1B-19-00-00-00; 9 = MAC 01-80-C2-00-00-0E.
- R2: Each rule is the AND of two comparators. Rules 0..3 pair comparators {0,4},{0,5},{1,4},{1,5}. Rules 4..7 pair {2,4},{2,5},{3,4},{3,5}. Rules 8..11 pair {8,6},{9,6},{8,7},{9,7}. Rules 12..13 pair {10,6},{10,7}. A 1 in bit j of `cfg_rule_mask` removes rule j, and with every rule masked nothing is detected.
- R3: Rules 0..3 can hold only in a frame whose Ethertype is 0x0800. Rules 4..7 can hold only in a frame whose Ethertype is 0x86DD.
- R4: `cfg_enable[0]` enables detection, `cfg_enable[1]` accepts version 1 and `cfg_enable[2]` accepts version 2. The version is the low nibble of time-protocol header byte 1. Nothing is detected unless bit 0 is set and the accept bit for the frame's version is set.
- R5: The time-protocol header starts at frame byte 14 for a non-IP frame, at byte 14 + 4*IHL + 8 for IPv4 (IHL is the low nibble of byte 14), and at byte 62 for IPv6. The UDP destination port occupies bytes 2..3 of the UDP header.
- R6: The sequence number comes from time-protocol header bytes 30 (high byte) and 31 (low byte), and `seq_id_o` carries it while `detect_o` is high.
- R7: A frame that ends before header byte 31 has arrived produces no pulse.
- R8: `detect_o` goes high in exactly the one cycle after the byte that carries `frame_eof`, and it is low after reset.
- R9: Comparator 2 ignores the scope nibble (bits 115:112 of the address). Comparator 7 compares the Ethertype with `cfg_ethertype`, and comparator 10 compares the MAC destination with `cfg_mac_da`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | A frame byte is present on `byte_data` |
| byte_data | input | 8 | Frame byte |
| frame_sof | input | 1 | Marks the first byte of a frame |
| frame_eof | input | 1 | Marks the last byte of a frame |
| cfg_param_mask | input | 11 | Per-comparator disable bits |
| cfg_rule_mask | input | 14 | Per-rule disable bits |
| cfg_enable | input | 3 | {v2 accept, v1 accept, enable} |
| cfg_ethertype | input | 16 | Configurable Ethertype for comparator 7 |
| cfg_mac_da | input | 48 | Configurable MAC destination for comparator 10 |
| detect_o | output | 1 | One-cycle event-frame detect pulse |
| seq_id_o | output | 16 | Captured sequence number, valid with `detect_o` |

## Verification
The only result this block produces is the pair `detect_o` and `seq_id_o`. They are due in the first cycle after the clock edge that accepts the byte marked `frame_eof`. One field register and one end-of-frame flag sit between that edge and the outputs. Each scenario drives its bytes on falling edges and samples both outputs on the first falling edge after the last byte. It then samples once more on the next falling edge to confirm the pulse has already dropped. Configuration is changed only between frames.

// File: rtl/ptpc_pkg.sv
package ptpc_pkg;
  localparam int NUM_PARAMS = 11;
  localparam int NUM_RULES  = 14;

  // comparator indices
  localparam int P_V4A = 0, P_V4B = 1, P_V6A = 2, P_V6B = 3;
  localparam int P_U0 = 4, P_U1 = 5, P_ET0 = 6, P_ETC = 7;
  localparam int P_MAC0 = 8, P_MAC1 = 9, P_MACC = 10;

  typedef struct packed {
    logic [47:0]  mac_da;
    logic [15:0]  etype;
    logic [3:0]   ihl;
    logic [31:0]  v4_da;
    logic [127:0] v6_da;
    logic [15:0]  dport;
    logic [3:0]   ver;
    logic [15:0]  seq;
    logic         seq_done;
  } ptpc_fields_t;

  // first comparator of rule r
  function automatic int rule_first(input int r);
    if (r < 8)       return r / 2;
    else if (r < 12) return P_MAC0 + (r % 2);
    else             return P_MACC;
  endfunction

  // second comparator of rule r
  function automatic int rule_second(input int r);
    if (r < 8)       return P_U0 + (r % 2);
    else if (r < 12) return P_ET0 + ((r - 8) / 2);
    else             return P_ET0 + (r - 12);
  endfunction

  // version acceptance
  function automatic logic version_ok(input logic [3:0] ver, input logic [2:0] en);
    return en[0] && ((ver == 4'd1 && en[1]) || (ver == 4'd2 && en[2]));
  endfunction
endpackage

// File: rtl/ptpc_field_extract.sv
module ptpc_field_extract
  import ptpc_pkg::*;
#(
  parameter int POS_W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [7:0]   in_data,
  input  logic         in_sof,
  output ptpc_fields_t fields_o,
  output logic         is_v4_o,
  output logic         is_v6_o
);
  localparam logic [POS_W-1:0] POS_MAX = '1;
  localparam logic [POS_W-1:0] ETH_HDR = POS_W'(14);

  ptpc_fields_t f_q, f_d;
  logic [POS_W-1:0] pos_q, cur_pos, udp_base, ptp_base;
  logic is_v4, is_v6;

  assign is_v4   = (f_q.etype == 16'h0800);
  assign is_v6   = (f_q.etype == 16'h86DD);
  assign cur_pos = in_sof ? '0 : pos_q;

  assign udp_base = is_v6 ? POS_W'(54) : ETH_HDR + POS_W'({f_q.ihl, 2'b00});
  assign ptp_base = (is_v4 || is_v6) ? udp_base + POS_W'(8) : ETH_HDR;

  always_comb begin
    f_d = in_sof ? '0 : f_q;
    if (cur_pos < POS_W'(6))
      f_d.mac_da = {f_d.mac_da[39:0], in_data};
    if (cur_pos == POS_W'(12) || cur_pos == POS_W'(13))
      f_d.etype = {f_d.etype[7:0], in_data};
    if (is_v4 && cur_pos == ETH_HDR)
      f_d.ihl = in_data[3:0];
    if (is_v4 && cur_pos >= POS_W'(30) && cur_pos <= POS_W'(33))
      f_d.v4_da = {f_d.v4_da[23:0], in_data};
    if (is_v6 && cur_pos >= POS_W'(38) && cur_pos <= POS_W'(53))
      f_d.v6_da = {f_d.v6_da[119:0], in_data};
    if ((is_v4 || is_v6) &&
        (cur_pos == udp_base + POS_W'(2) || cur_pos == udp_base + POS_W'(3)))
      f_d.dport = {f_d.dport[7:0], in_data};
    if (cur_pos == ptp_base + POS_W'(1))
      f_d.ver = in_data[3:0];
    if (!f_q.seq_done &&
        (cur_pos == ptp_base + POS_W'(30) || cur_pos == ptp_base + POS_W'(31)))
      f_d.seq = {f_d.seq[7:0], in_data};
    if (!f_q.seq_done && cur_pos == ptp_base + POS_W'(31))
      f_d.seq_done = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_q   <= '0;
      pos_q <= '0;
    end else if (in_valid) begin
      f_q   <= f_d;
      pos_q <= (cur_pos == POS_MAX) ? POS_MAX : cur_pos + POS_W'(1);
    end
  end

  assign fields_o = f_q;
  assign is_v4_o  = is_v4;
  assign is_v6_o  = is_v6;

  AST_SEQ_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (f_q.seq_done && !(in_valid && in_sof)) |=> f_q.seq_done)
    else $error("seq_done dropped mid-frame"); // R6
endmodule

// File: rtl/ptpc_rule_match.sv
module ptpc_rule_match
  import ptpc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  ptpc_fields_t          fields_i,
  input  logic                  is_v4_i,
  input  logic                  is_v6_i,
  input  logic [NUM_PARAMS-1:0] param_mask_i,
  input  logic [NUM_RULES-1:0]  rule_mask_i,
  input  logic [15:0]           cfg_ethertype_i,
  input  logic [47:0]           cfg_mac_da_i,
  output logic [NUM_PARAMS-1:0] param_hit_o,
  output logic [NUM_RULES-1:0]  rule_hit_o,
  output logic                  any_rule_o
);
  logic [NUM_PARAMS-1:0] raw_hit;

  always_comb begin
    raw_hit          = '0;
    raw_hit[P_V4A]   = (fields_i.v4_da == 32'hE000_0181);
    raw_hit[P_V4B]   = (fields_i.v4_da == 32'hE000_006B);
    raw_hit[P_V6A]   = ({fields_i.v6_da[127:116], fields_i.v6_da[111:0]} ==
                        {12'hFF0, 112'h181});
    raw_hit[P_V6B]   = (fields_i.v6_da == {16'hFF02, 96'h0, 16'h006B});
    raw_hit[P_U0]    = (fields_i.dport == 16'd319);
    raw_hit[P_U1]    = (fields_i.dport == 16'd320);
    raw_hit[P_ET0]   = (fields_i.etype == 16'h88F7);
    raw_hit[P_ETC]   = (fields_i.etype == cfg_ethertype_i);
    raw_hit[P_MAC0]  = (fields_i.mac_da == 48'h011B_1900_0000);
    raw_hit[P_MAC1]  = (fields_i.mac_da == 48'h0180_C200_000E);
    raw_hit[P_MACC]  = (fields_i.mac_da == cfg_mac_da_i);
  end

  assign param_hit_o = raw_hit & ~param_mask_i;

  for (genvar r = 0; r < NUM_RULES; r++) begin : g_rule
    localparam int A = rule_first(r);
    localparam int B = rule_second(r);
    logic gate;
    if (r < 4) begin : g_v4
      assign gate = is_v4_i;
    end else if (r < 8) begin : g_v6
      assign gate = is_v6_i;
    end else begin : g_l2
      assign gate = 1'b1;
    end
    assign rule_hit_o[r] = gate && param_hit_o[A] && param_hit_o[B] && !rule_mask_i[r];
  end

  assign any_rule_o = |rule_hit_o;

  AST_V4_RULES_NEED_V4: assert property (@(posedge clk) disable iff (!rst_n)
    (|rule_hit_o[3:0]) |-> (fields_i.etype == 16'h0800))
    else $error("IPv4 rule hit on non-IPv4 frame"); // R3
  AST_V6_RULES_NEED_V6: assert property (@(posedge clk) disable iff (!rst_n)
    (|rule_hit_o[7:4]) |-> (fields_i.etype == 16'h86DD))
    else $error("IPv6 rule hit on non-IPv6 frame"); // R3
  AST_MASKED_PARAM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (&param_mask_i) |-> !any_rule_o)
    else $error("rule hit with all comparators masked"); // R1
endmodule

// File: rtl/ptp_frame_classifier.sv
module ptp_frame_classifier
  import ptpc_pkg::*;
#(
  parameter int POS_W = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  byte_valid,
  input  logic [7:0]            byte_data,
  input  logic                  frame_sof,
  input  logic                  frame_eof,
  input  logic [NUM_PARAMS-1:0] cfg_param_mask,
  input  logic [NUM_RULES-1:0]  cfg_rule_mask,
  input  logic [2:0]            cfg_enable,
  input  logic [15:0]           cfg_ethertype,
  input  logic [47:0]           cfg_mac_da,
  output logic                  detect_o,
  output logic [15:0]           seq_id_o
);
  ptpc_fields_t          fields;
  logic                  is_v4, is_v6, any_rule, ver_accept, eof_q;
  logic [NUM_PARAMS-1:0] param_hit;
  logic [NUM_RULES-1:0]  rule_hit;

  ptpc_field_extract #(.POS_W(POS_W)) extract_i (
    .clk(clk), .rst_n(rst_n), .in_valid(byte_valid), .in_data(byte_data),
    .in_sof(frame_sof), .fields_o(fields), .is_v4_o(is_v4), .is_v6_o(is_v6)
  );

  ptpc_rule_match match_i (
    .clk(clk), .rst_n(rst_n), .fields_i(fields), .is_v4_i(is_v4), .is_v6_i(is_v6),
    .param_mask_i(cfg_param_mask), .rule_mask_i(cfg_rule_mask),
    .cfg_ethertype_i(cfg_ethertype), .cfg_mac_da_i(cfg_mac_da),
    .param_hit_o(param_hit), .rule_hit_o(rule_hit), .any_rule_o(any_rule)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) eof_q <= 1'b0;
    else        eof_q <= byte_valid && frame_eof;
  end

  assign ver_accept = version_ok(fields.ver, cfg_enable);
  assign detect_o   = eof_q && fields.seq_done && ver_accept && any_rule;
  assign seq_id_o   = detect_o ? fields.seq : 16'h0;

  AST_DETECT_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    detect_o |-> $past(byte_valid && frame_eof))
    else $error("detect without preceding end of frame"); // R8
  AST_DETECT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    detect_o |=> !detect_o)
    else $error("detect held longer than one cycle"); // R8
  AST_NO_DETECT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable[0] |-> !detect_o)
    else $error("detect while disabled"); // R4
  AST_DETECT_NEEDS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    detect_o |-> fields.seq_done)
    else $error("detect on short frame"); // R7
  AST_ALL_RULES_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (&cfg_rule_mask) |-> !detect_o)
    else $error("detect with all rules masked"); // R2
endmodule

// File: tb/ptp_frame_classifier_tb.sv
`timescale 1ns/1ps
module ptp_frame_classifier_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = 8'h0;
  logic        frame_sof = 1'b0;
  logic        frame_eof = 1'b0;
  logic [10:0] cfg_param_mask = '1;
  logic [13:0] cfg_rule_mask = '1;
  logic [2:0]  cfg_enable = 3'b000;
  logic [15:0] cfg_ethertype = 16'h0;
  logic [47:0] cfg_mac_da = 48'h0;
  logic        detect_o;
  logic [15:0] seq_id_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] fb [0:255];
  int flen = 0;

  always #4 clk = ~clk;

  ptp_frame_classifier dut_i (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .frame_sof(frame_sof), .frame_eof(frame_eof), .cfg_param_mask(cfg_param_mask),
    .cfg_rule_mask(cfg_rule_mask), .cfg_enable(cfg_enable),
    .cfg_ethertype(cfg_ethertype), .cfg_mac_da(cfg_mac_da),
    .detect_o(detect_o), .seq_id_o(seq_id_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_frame();
    for (int i = 0; i < 256; i++) fb[i] = 8'h00;
  endtask

  task automatic put_ptp(input int base, input logic [3:0] ver, input logic [15:0] seq);
    fb[base + 1]  = {4'h0, ver};
    fb[base + 30] = seq[15:8];
    fb[base + 31] = seq[7:0];
    flen = base + 44;
  endtask

  task automatic build_raw(input logic [47:0] mac, input logic [15:0] et,
                           input logic [3:0] ver, input logic [15:0] seq);
    clear_frame();
    for (int i = 0; i < 6; i++) fb[i] = mac[47 - 8*i -: 8];
    fb[12] = et[15:8]; fb[13] = et[7:0];
    put_ptp(14, ver, seq);
  endtask

  task automatic build_v4(input logic [3:0] ihl, input logic [31:0] da,
                          input logic [15:0] port, input logic [3:0] ver,
                          input logic [15:0] seq);
    int udp;
    clear_frame();
    fb[0] = 8'h01; fb[1] = 8'h00; fb[2] = 8'h5E;
    fb[12] = 8'h08; fb[13] = 8'h00;
    fb[14] = {4'h4, ihl}; fb[23] = 8'd17;
    for (int i = 0; i < 4; i++) fb[30 + i] = da[31 - 8*i -: 8];
    udp = 14 + 4*ihl;
    fb[udp + 2] = port[15:8]; fb[udp + 3] = port[7:0];
    put_ptp(udp + 8, ver, seq);
  endtask

  task automatic build_v6(input logic [127:0] da, input logic [15:0] port,
                          input logic [3:0] ver, input logic [15:0] seq);
    clear_frame();
    fb[0] = 8'h33; fb[1] = 8'h33;
    fb[12] = 8'h86; fb[13] = 8'hDD;
    fb[14] = 8'h60; fb[20] = 8'd17;
    for (int i = 0; i < 16; i++) fb[38 + i] = da[127 - 8*i -: 8];
    fb[56] = port[15:8]; fb[57] = port[7:0];
    put_ptp(62, ver, seq);
  endtask

  // sends fb[0..flen-1], then checks the pulse in the cycle after the last byte
  task automatic send_check(input string req, input bit exp_det, input logic [15:0] exp_seq);
    for (int i = 0; i < flen; i++) begin
      @(negedge clk);
      byte_valid = 1'b1; byte_data = fb[i];
      frame_sof = (i == 0); frame_eof = (i == flen - 1);
    end
    @(negedge clk);
    byte_valid = 1'b0; frame_sof = 1'b0; frame_eof = 1'b0;
    chk(detect_o == exp_det, req, "detect", int'(detect_o), int'(exp_det));
    if (exp_det) chk(seq_id_o == exp_seq, req, "seq_id", int'(seq_id_o), int'(exp_seq));
    @(negedge clk);
    chk(detect_o == 1'b0, req, "pulse width", int'(detect_o), 0);
  endtask

  function automatic logic [13:0] only_rule(input int r);
    return ~(14'd1 << r);
  endfunction
  function automatic logic [10:0] only_params(input int a, input int b);
    return ~((11'd1 << a) | (11'd1 << b));
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk(detect_o == 1'b0, "R8", "reset detect", int'(detect_o), 0);
  endtask

  task automatic t_layer2();
    cfg_enable = 3'b101; cfg_param_mask = '1; cfg_rule_mask = '1;
    build_raw(48'h011B_1900_0000, 16'h88F7, 4'd2, 16'hABCD);
    send_check("R2", 1'b0, 16'h0);                // all masked
    cfg_param_mask = only_params(8, 6); cfg_rule_mask = only_rule(8);
    send_check("R6", 1'b1, 16'hABCD);             // rule 8 hits, seq big-endian
    cfg_rule_mask = only_rule(9);
    send_check("R2", 1'b0, 16'h0);                // wrong rule enabled
    cfg_param_mask = only_params(8, 6) | 11'b000_0100_0000; cfg_rule_mask = only_rule(8);
    send_check("R1", 1'b0, 16'h0);                // comparator 6 masked
    cfg_param_mask = only_params(9, 6); cfg_rule_mask = only_rule(9);
    build_raw(48'h0180_C200_000E, 16'h88F7, 4'd2, 16'h0102);
    send_check("R2", 1'b1, 16'h0102);
  endtask

  task automatic t_enables();
    cfg_param_mask = only_params(8, 6); cfg_rule_mask = only_rule(8);
    build_raw(48'h011B_1900_0000, 16'h88F7, 4'd2, 16'h1234);
    cfg_enable = 3'b011;
    send_check("R4", 1'b0, 16'h0);                // v2 frame, only v1 accepted
    cfg_enable = 3'b110;
    send_check("R4", 1'b0, 16'h0);                // master enable off
    build_raw(48'h011B_1900_0000, 16'h88F7, 4'd1, 16'h5678);
    cfg_enable = 3'b011;
    send_check("R4", 1'b1, 16'h5678);             // v1 accepted
  endtask

  task automatic t_ipv4();
    cfg_enable = 3'b101;
    cfg_param_mask = only_params(0, 4); cfg_rule_mask = only_rule(0);
    build_v4(4'd5, 32'hE000_0181, 16'd319, 4'd2, 16'h4001);
    send_check("R5", 1'b1, 16'h4001);
    build_v4(4'd7, 32'hE000_0181, 16'd319, 4'd2, 16'h4002);
    send_check("R5", 1'b1, 16'h4002);             // IHL with options
    cfg_param_mask = only_params(1, 5); cfg_rule_mask = only_rule(3);
    build_v4(4'd5, 32'hE000_006B, 16'd320, 4'd2, 16'h4003);
    send_check("R2", 1'b1, 16'h4003);
    build_v4(4'd5, 32'hE000_006B, 16'd319, 4'd2, 16'h4004);
    send_check("R2", 1'b0, 16'h0);                // port mismatch
  endtask

  task automatic t_ipv6();
    cfg_enable = 3'b101;
    cfg_param_mask = only_params(3, 5); cfg_rule_mask = ~14'b0000_0000_0000_1111;
    build_v6({16'hFF02, 96'h0, 16'h006B}, 16'd320, 4'd2, 16'h6001);
    send_check("R3", 1'b0, 16'h0);                // only IPv4 rules enabled
    cfg_rule_mask = only_rule(7);
    send_check("R3", 1'b1, 16'h6001);
    cfg_param_mask = only_params(2, 4); cfg_rule_mask = only_rule(4);
    build_v6({16'hFF05, 96'h0, 16'h0181}, 16'd319, 4'd2, 16'h6002);
    send_check("R9", 1'b1, 16'h6002);             // scope nibble wildcard
    build_v6({16'hFF15, 96'h0, 16'h0181}, 16'd319, 4'd2, 16'h6003);
    send_check("R9", 1'b0, 16'h0);                // non-wildcard nibble
  endtask

  task automatic t_configurable();
    cfg_enable = 3'b101;
    cfg_ethertype = 16'h88B5; cfg_mac_da = 48'h0200_DEAD_BEEF;
    cfg_param_mask = only_params(10, 7); cfg_rule_mask = only_rule(13);
    build_raw(48'h0200_DEAD_BEEF, 16'h88B5, 4'd2, 16'h7777);
    send_check("R9", 1'b1, 16'h7777);
    build_raw(48'h0200_DEAD_BEEE, 16'h88B5, 4'd2, 16'h7778);
    send_check("R9", 1'b0, 16'h0);
  endtask

  task automatic t_short();
    cfg_enable = 3'b101;
    cfg_param_mask = only_params(8, 6); cfg_rule_mask = only_rule(8);
    build_raw(48'h011B_1900_0000, 16'h88F7, 4'd2, 16'h9999);
    flen = 14 + 31;                               // ends before header byte 31
    send_check("R7", 1'b0, 16'h0);
    flen = 14 + 32;                               // ends on header byte 31
    send_check("R7", 1'b1, 16'h9999);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_layer2();
    t_enables();
    t_ipv4();
    t_ipv6();
    t_configurable();
    t_short();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule